// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This block sits between the register side of a 32-bit datapath and a byte-addressed data memory. It has no state. On the load side it takes the whole 32-bit word read from memory, the two low address bits, an access size and a signedness flag. It returns the selected byte, halfword or word, right-justified and extended, ready for the register-file write port.

On the store side it takes the register value, the same address bits and size, and a store request. It produces the memory write data with the operand copied into every lane. It also produces a 4-bit byte-enable mask that marks only the addressed lanes.

Accesses that do not sit on their natural boundary raise a misalignment flag, and a store is then suppressed. The whole unit is combinational, so results follow the inputs within the same cycle.

Top module: `lsu_align`

## Requirements
- R1: With `acc_size`=2'b00 and `zero_ext`=0, `ld_result[7:0]` is the byte of `mem_rdata` at lane `addr_lo` (lane n is bits 8n+7:8n, little-endian), and bits 31:8 all equal that byte's bit 7.
- R2: With `acc_size`=2'b00 and `zero_ext`=1, `ld_result[7:0]` is the byte at lane `addr_lo` and bits 31:8 are zero.
- R3: With `acc_size`=2'b01, `ld_result[15:0]` is `mem_rdata[31:16]` when `addr_lo[1]`=1, else `mem_rdata[15:0]`. Bits 31:16 copy bit 15 when `zero_ext`=0 and are zero when `zero_ext`=1. `addr_lo[0]` does not change the loaded data.
- R4: With `acc_size[1]`=1 (word; 2'b11 is treated as word), `ld_result` equals `mem_rdata` regardless of `zero_ext` and `addr_lo`.
- R5: `st_wdata` is `{4{st_src[7:0]}}` for byte size, `{2{st_src[15:0]}}` for halfword size and `st_src` for word size.
- R6: For an aligned access with `st_req`=1, `st_be` is 4'b0001 shifted left by `addr_lo` for byte size. For halfword size it is 4'b0011 when `addr_lo[1]`=0 and 4'b1100 otherwise. For word size it is 4'b1111.
- R7: `misaligned` is 1 exactly when a halfword access has `addr_lo[0]`=1 or a word access has `addr_lo`≠0. `st_be` is then 4'b0000 even with `st_req`=1.
- R8: With `st_req`=0, `st_be` is 4'b0000 for every size and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mem_rdata | input | 32 | Word read from data memory |
| addr_lo | input | 2 | Low two bits of the byte address |
| acc_size | input | 2 | 00 byte, 01 halfword, 1x word |
| zero_ext | input | 1 | 1 selects zero extension for loads |
| st_req | input | 1 | Store is being issued this cycle |
| st_src | input | 32 | Register value to be stored |
| ld_result | output | 32 | Aligned, extended load value |
| st_wdata | output | 32 | Lane-replicated store data |
| st_be | output | 4 | Byte enables for the store |
| misaligned | output | 1 | Access is not on its natural boundary |

## Verification
With no state inside, a wrong lane select or extension rule shows at `ld_result` or `st_wdata` in the same cycle as the inputs that expose it. It does not hide for later. The load side is checked over every size, signedness and offset against an independent model, on several memory words. A stray enable on a misaligned or idle store would corrupt neighbouring bytes at once, so `st_be` is compared against a model for every store combination.

// File: rtl/lsu_align.sv
module lsu_align (
  input  logic [31:0] mem_rdata,
  input  logic [1:0]  addr_lo,
  input  logic [1:0]  acc_size,
  input  logic        zero_ext,
  input  logic        st_req,
  input  logic [31:0] st_src,
  output logic [31:0] ld_result,
  output logic [31:0] st_wdata,
  output logic [3:0]  st_be,
  output logic        misaligned
);

  logic [7:0]  lane_byte;
  logic [15:0] lane_half;
  logic [3:0]  be_raw;

  assign lane_byte = mem_rdata[{addr_lo, 3'b000} +: 8];
  assign lane_half = addr_lo[1] ? mem_rdata[31:16] : mem_rdata[15:0];

  always_comb begin
    case (acc_size)
      2'b00:   ld_result = {{24{~zero_ext & lane_byte[7]}}, lane_byte};
      2'b01:   ld_result = {{16{~zero_ext & lane_half[15]}}, lane_half};
      default: ld_result = mem_rdata;
    endcase
  end

  assign misaligned = (acc_size == 2'b01 && addr_lo[0]) ||
                      (acc_size[1] && addr_lo != 2'b00);

  always_comb begin
    case (acc_size)
      2'b00: begin
        st_wdata = {4{st_src[7:0]}};
        be_raw   = 4'b0001 << addr_lo;
      end
      2'b01: begin
        st_wdata = {2{st_src[15:0]}};
        be_raw   = addr_lo[1] ? 4'b1100 : 4'b0011;
      end
      default: begin
        st_wdata = st_src;
        be_raw   = 4'b1111;
      end
    endcase
  end

  assign st_be = (st_req && !misaligned) ? be_raw : 4'b0000;

endmodule

module lsu_align_chk (
  input logic [31:0] mem_rdata,
  input logic [1:0]  addr_lo,
  input logic [1:0]  acc_size,
  input logic        zero_ext,
  input logic        st_req,
  input logic [31:0] ld_result,
  input logic [3:0]  st_be,
  input logic        misaligned
);
  logic known;
  assign known = !$isunknown({mem_rdata, addr_lo, acc_size, zero_ext, st_req});

  always_comb begin
    if (known) begin
      if (acc_size == 2'b00 && !zero_ext)
        assert_byte_sext_R1: assert (ld_result[31:8] == {24{ld_result[7]}});
      if (acc_size == 2'b00 && zero_ext)
        assert_byte_zext_R2: assert (ld_result[31:8] == 24'h0);
      if (acc_size == 2'b01 && zero_ext)
        assert_half_zext_R3: assert (ld_result[31:16] == 16'h0);
      if (acc_size[1])
        assert_word_pass_R4: assert (ld_result == mem_rdata);
      if (st_req && !misaligned)
        assert_be_count_R6: assert ($countones(st_be) ==
          (acc_size == 2'b00 ? 1 : (acc_size == 2'b01 ? 2 : 4)));
      if (misaligned)
        assert_misaligned_no_be_R7: assert (st_be == 4'b0000);
      if (!st_req)
        assert_idle_no_be_R8: assert (st_be == 4'b0000);
    end
  end
endmodule

bind lsu_align lsu_align_chk u_chk (
  .mem_rdata(mem_rdata), .addr_lo(addr_lo), .acc_size(acc_size),
  .zero_ext(zero_ext), .st_req(st_req), .ld_result(ld_result),
  .st_be(st_be), .misaligned(misaligned)
);

// File: tb/tb_lsu_align.sv
module tb_lsu_align;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] mem_rdata, st_src;
  logic [1:0]  addr_lo, acc_size;
  logic        zero_ext, st_req;
  logic [31:0] ld_result, st_wdata;
  logic [3:0]  st_be;
  logic        misaligned;

  int total = 0;
  int bad = 0;

  lsu_align dut (
    .mem_rdata(mem_rdata), .addr_lo(addr_lo), .acc_size(acc_size),
    .zero_ext(zero_ext), .st_req(st_req), .st_src(st_src),
    .ld_result(ld_result), .st_wdata(st_wdata), .st_be(st_be),
    .misaligned(misaligned)
  );

  localparam logic [31:0] VW = 32'h8CF3_7A15;
  // {size, zero_ext, addr, expected load}
  localparam logic [36:0] VEC [8] = '{
    {2'b00, 1'b0, 2'd0, 32'h0000_0015},
    {2'b00, 1'b0, 2'd2, 32'hFFFF_FFF3},
    {2'b00, 1'b1, 2'd3, 32'h0000_008C},
    {2'b00, 1'b0, 2'd3, 32'hFFFF_FF8C},
    {2'b01, 1'b0, 2'd0, 32'h0000_7A15},
    {2'b01, 1'b0, 2'd2, 32'hFFFF_8CF3},
    {2'b01, 1'b1, 2'd2, 32'h0000_8CF3},
    {2'b10, 1'b1, 2'd1, 32'h8CF3_7A15}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_load(logic [31:0] w, logic [1:0] sz, logic u, logic [1:0] a);
    logic [7:0] b;
    logic [15:0] h;
    b = w[8*a +: 8];
    h = a[1] ? w[31:16] : w[15:0];
    if (sz == 2'b00) return u ? {24'h0, b} : {{24{b[7]}}, b};
    if (sz == 2'b01) return u ? {16'h0, h} : {{16{h[15]}}, h};
    return w;
  endfunction

  function automatic logic m_mis(logic [1:0] sz, logic [1:0] a);
    return (sz == 2'b01 && a[0]) || (sz[1] && a != 2'd0);
  endfunction

  function automatic logic [3:0] m_be(logic [1:0] sz, logic [1:0] a, logic rq);
    if (!rq || m_mis(sz, a)) return 4'b0000;
    if (sz == 2'b00) return 4'b0001 << a;
    if (sz == 2'b01) return a[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] m_wd(logic [31:0] s, logic [1:0] sz);
    if (sz == 2'b00) return {4{s[7:0]}};
    if (sz == 2'b01) return {2{s[15:0]}};
    return s;
  endfunction

  function automatic string tag(logic [1:0] sz, logic u);
    if (sz == 2'b00) return u ? "R2" : "R1";
    if (sz == 2'b01) return "R3";
    return "R4";
  endfunction

  task automatic drive(logic [31:0] w, logic [1:0] sz, logic u, logic [1:0] a,
                       logic rq, logic [31:0] s);
    @(negedge clk);
    mem_rdata = w; acc_size = sz; zero_ext = u; addr_lo = a; st_req = rq; st_src = s;
    #1;
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] words [4];
    words[0] = 32'h8CF3_7A15; words[1] = 32'h7F80_01FF;
    words[2] = 32'h0000_0000; words[3] = 32'hFFFF_FFFF;

    // idle state: all inputs zero
    drive(32'h0, 2'b00, 1'b0, 2'd0, 1'b0, 32'h0);
    chk("R8 idle be", {28'h0, st_be}, 32'h0);
    chk("R1 idle load", ld_result, 32'h0);
    chk("R7 idle misaligned", {31'h0, misaligned}, 32'h0);

    for (int i = 0; i < 8; i++) begin
      drive(VW, VEC[i][36:35], VEC[i][34], VEC[i][33:32], 1'b0, 32'h0);
      chk(tag(VEC[i][36:35], VEC[i][34]), ld_result, VEC[i][31:0]);
    end

    for (int k = 0; k < 4; k++)
      for (int sz = 0; sz < 4; sz++)
        for (int u = 0; u < 2; u++)
          for (int a = 0; a < 4; a++) begin
            drive(words[k], sz[1:0], u[0], a[1:0], 1'b0, 32'h0);
            chk(tag(sz[1:0], u[0]), ld_result, m_load(words[k], sz[1:0], u[0], a[1:0]));
            chk("R7 flag", {31'h0, misaligned}, {31'h0, m_mis(sz[1:0], a[1:0])});
          end

    for (int sz = 0; sz < 4; sz++)
      for (int rq = 0; rq < 2; rq++)
        for (int a = 0; a < 4; a++) begin
          drive(32'h0, sz[1:0], 1'b0, a[1:0], rq[0], 32'hA1B2_C3D4);
          chk("R5 wdata", st_wdata, m_wd(32'hA1B2_C3D4, sz[1:0]));
          chk(rq[0] ? (m_mis(sz[1:0], a[1:0]) ? "R7 be" : "R6 be") : "R8 be",
              {28'h0, st_be}, {28'h0, m_be(sz[1:0], a[1:0], rq[0])});
        end

    // corner cases
    drive(32'h0, 2'b01, 1'b0, 2'd3, 1'b1, 32'h1234_5678);
    chk("R7 half at 3 be", {28'h0, st_be}, 32'h0);
    chk("R7 half at 3 flag", {31'h0, misaligned}, 32'h1);
    drive(32'h0, 2'b11, 1'b0, 2'd2, 1'b1, 32'h1234_5678);
    chk("R7 word at 2 be", {28'h0, st_be}, 32'h0);
    drive(32'h0, 2'b11, 1'b0, 2'd0, 1'b1, 32'h1234_5678);
    chk("R6 size 11 word be", {28'h0, st_be}, 32'hF);
    chk("R5 size 11 wdata", st_wdata, 32'h1234_5678);
    drive(32'hBEEF_0000, 2'b01, 1'b1, 2'd3, 1'b0, 32'h0);
    chk("R3 addr bit0 ignored", ld_result, 32'h0000_BEEF);
    drive(32'h0000_80AA, 2'b00, 1'b0, 2'd1, 1'b0, 32'h0);
    chk("R1 lane1 sign", ld_result, 32'hFFFF_FF80);
    drive(32'h0000_80AA, 2'b10, 1'b0, 2'd3, 1'b0, 32'h0);
    chk("R4 word ignores addr", ld_result, 32'h0000_80AA);
    drive(32'h0, 2'b00, 1'b0, 2'd3, 1'b1, 32'h0000_00E7);
    chk("R6 byte lane3 be", {28'h0, st_be}, 32'h8);
    chk("R5 byte replicate", st_wdata, 32'hE7E7_E7E7);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule